// File: doc/BRIEF.md
# GPIO Per-Line Interrupt Detector

This block watches a bank of general-purpose pins and, for every line, decides in each clock cycle whether that line's interrupt status bit should be set. It passes the raw pad levels through a synchronizer. It then compares each line's newly sampled level with the level it held one sample earlier, and applies the mode that line is configured for. The result is a vector of set requests that a surrounding status register ORs into its bits. Masking, clearing and bus access belong to that surrounding logic.

Each line takes a two-bit mode code from a packed configuration word. The upper bit of the code selects edge or level sensitivity. The lower bit selects the active polarity in level mode, and selects which edge is ignored in edge mode. A separate per-line bit overrides the code and reports any change of level. A line configured as an output never requests. The block also presents the sampled pad state it compares against.

Top module: `gpio_irq_detect`

## Requirements
- R1: While rst_n is low, set_req and pad_level are all zero, and the synchronizer and the sampled-level register are cleared.
- R2: A line whose dir_out bit is 1 (output) never raises its set_req bit, whatever its mode and pin activity.
- R3: A line whose any_edge_en bit is 1 raises set_req for exactly one cycle on each change of its sampled level, rising or falling, regardless of its mode code.
- R4: Mode code 2'b10 (edge, lower bit 0) raises a one-cycle request only when the sampled level changes from 0 to 1.
- R5: Mode code 2'b11 (edge, lower bit 1) raises a one-cycle request only when the sampled level changes from 1 to 0.
- R6: Mode code 2'b00 (level, lower bit 0) holds the request high on every cycle in which the sampled level is 0.
- R7: Mode code 2'b01 (level, lower bit 1) holds the request high on every cycle in which the sampled level is 1.
- R8: A change on pad_in is first seen by detection after two clock edges. The request of an edge-mode line is high in the cycle that follows the second edge and low again after the third.
- R9: pad_level shows the sampled level that the current comparison uses as "previous". It takes the new sampled level one edge after that level was compared.
- R10: Line n takes its code from mode_cfg bits 2n+1 (edge select) and 2n (polarity). Bits 31:0 therefore configure lines 0 to 15, and bits 63:32 configure lines 16 to 31.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pad_in | input | 32 | Asynchronous pad levels |
| dir_out | input | 32 | Per-line direction, 1 = output |
| mode_cfg | input | 64 | Two-bit mode code per line |
| any_edge_en | input | 32 | Per-line override: request on any change |
| set_req | output | 32 | Per-line status set requests |
| pad_level | output | 32 | Sampled pad state (previous sample) |

## Verification
The hardest case to reach is a configuration change that lands between two samples of the same pin level. Examples are a line switching from level mode to edge mode while its level is held, or a line flipping its direction while its override bit is set. Such a change must not create a false edge. The stimulus therefore holds the pads still and rewrites the mode codes, override bits and directions at random on those idle cycles. In other phases it toggles pins under a fixed configuration. A behavioural model built from a queue of past pad samples is compared against every line on every cycle.

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int LINES       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LINES-1:0]   pad_in,
  input  logic [LINES-1:0]   dir_out,
  input  logic [2*LINES-1:0] mode_cfg,
  input  logic [LINES-1:0]   any_edge_en,
  output logic [LINES-1:0]   set_req,
  output logic [LINES-1:0]   pad_level
);

  logic [LINES-1:0] sync_q [SYNC_STAGES];
  logic [LINES-1:0] prev_q;
  logic [LINES-1:0] cur;
  logic [LINES-1:0] edge_sel;
  logic [LINES-1:0] pol;
  logic [LINES-1:0] hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < SYNC_STAGES; k++) sync_q[k] <= '0;
      prev_q <= '0;
    end else begin
      sync_q[0] <= pad_in;
      for (int k = 1; k < SYNC_STAGES; k++) sync_q[k] <= sync_q[k-1];
      prev_q <= cur;
    end
  end

  assign cur       = sync_q[SYNC_STAGES-1];
  assign pad_level = prev_q;

  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign edge_sel[i] = mode_cfg[2*i+1];
    assign pol[i]      = mode_cfg[2*i];
    always_comb begin
      if (any_edge_en[i])   hit[i] = cur[i] ^ prev_q[i];
      else if (edge_sel[i]) hit[i] = (cur[i] ^ prev_q[i]) & (cur[i] ^ pol[i]);
      else                  hit[i] = ~(cur[i] ^ pol[i]);
    end
  end

  assign set_req = rst_n ? (hit & ~dir_out) : '0;

  logic [1:0] warm_q;
  always_ff @(posedge clk) begin
    if (!rst_n) warm_q <= '0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  always_comb begin
    if (!rst_n) a_r1_reset_quiet: assert (set_req == '0);
  end

  a_r2_output_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (set_req & dir_out) == '0);

  a_r9_level_lag: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'd3) |-> (pad_level == $past(pad_in, 3)));

  a_r3_edge_needs_change: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'd3) |->
      ((set_req & (any_edge_en | edge_sel) & ~($past(pad_in, 2) ^ $past(pad_in, 3))) == '0));

endmodule

// File: tb/test_gpio_irq_detect.sv
module test_gpio_irq_detect;
  localparam int CLK_PERIOD = 10;
  localparam int N = 32;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [N-1:0]   pad_in = '0;
  logic [N-1:0]   dir_out = '0;
  logic [2*N-1:0] mode_cfg = '0;
  logic [N-1:0]   any_edge_en = '0;
  logic [N-1:0]   set_req;
  logic [N-1:0]   pad_level;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [N-1:0] hist [$];

  gpio_irq_detect i_gpio_irq_detect (
    .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .dir_out(dir_out),
    .mode_cfg(mode_cfg), .any_edge_en(any_edge_en),
    .set_req(set_req), .pad_level(pad_level));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic act, input logic exp, input int line);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s line %0d: actual=%b expected=%b at %0t", tag, line, act, exp, $time);
    end
  endtask

  task automatic model_compare();
    logic [N-1:0] now_l, old_l;
    now_l = hist[1];
    old_l = hist[2];
    for (int i = 0; i < N; i++) begin
      logic e;
      string tag;
      logic [1:0] code;
      code = mode_cfg[2*i +: 2];
      if (!rst_n) begin
        chk("R1", set_req[i], 1'b0, i);
        chk("R1", pad_level[i], 1'b0, i);
        continue;
      end
      if (dir_out[i]) begin e = 1'b0; tag = "R2"; end
      else if (any_edge_en[i]) begin e = now_l[i] != old_l[i]; tag = "R3"; end
      else begin
        case (code)
          2'b10: begin e = !old_l[i] && now_l[i]; tag = "R4"; end
          2'b11: begin e = old_l[i] && !now_l[i]; tag = "R5"; end
          2'b00: begin e = !now_l[i]; tag = "R6"; end
          default: begin e = now_l[i]; tag = "R7"; end
        endcase
      end
      chk(tag, set_req[i], e, i);
      chk("R9", pad_level[i], old_l[i], i);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    if (rst_n) begin
      hist.push_front(pad_in);
      void'(hist.pop_back());
    end else begin
      hist = '{'0, '0, '0};
    end
    #(CLK_PERIOD/4);
    model_compare();
  endtask

  task automatic rand_cfg();
    dir_out     = $urandom() & $urandom();
    any_edge_en = $urandom() & $urandom();
    mode_cfg    = {$urandom(), $urandom()};
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    hist = '{'0, '0, '0};
    pad_in = '1;
    mode_cfg = '0;
    for (int c = 0; c < 3; c++) tick();
    rst_n = 1'b1;

    // R8: latency on line 3 with any-change override; R10: line 16 from upper half
    pad_in = '0;
    for (int c = 0; c < 4; c++) tick();
    any_edge_en = 32'h8;
    mode_cfg = 64'h0;
    mode_cfg[33:32] = 2'b01;
    dir_out = ~32'h0001_0008;
    tick();
    pad_in[3] = 1'b1;
    pad_in[16] = 1'b1;
    tick(); chk("R8", set_req[3], 1'b0, 3);
    tick(); chk("R8", set_req[3], 1'b1, 3); chk("R10", set_req[16], 1'b1, 16);
    tick(); chk("R8", set_req[3], 1'b0, 3); chk("R10", set_req[16], 1'b1, 16);
    mode_cfg[33:32] = 2'b00;
    tick(); chk("R10", set_req[16], 1'b0, 16);
    mode_cfg[1:0] = 2'b01;
    tick(); chk("R10", set_req[0], 1'b0, 0);

    // toggling pads under fixed random configurations
    for (int p = 0; p < 40; p++) begin
      rand_cfg();
      for (int c = 0; c < 25; c++) begin
        pad_in = pad_in ^ ($urandom() & $urandom());
        tick();
      end
    end

    // configuration changes while pads are held still
    for (int p = 0; p < 300; p++) begin
      rand_cfg();
      tick();
      if (p % 10 == 0) pad_in = $urandom();
    end

    // all-input, every line in one mode, slow square wave
    dir_out = '0;
    any_edge_en = '0;
    for (int m = 0; m < 4; m++) begin
      for (int i = 0; i < N; i++) mode_cfg[2*i +: 2] = m[1:0];
      for (int c = 0; c < 24; c++) begin
        if (c % 5 == 0) pad_in = ~pad_in;
        tick();
      end
    end

    // reset in the middle of activity
    rst_n = 1'b0;
    pad_in = $urandom();
    tick(); tick();
    rst_n = 1'b1;
    for (int c = 0; c < 20; c++) begin
      pad_in = $urandom();
      tick();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule